// File: doc/BRIEF.md
# Single-Digit Iterative Calculator Datapath

This block takes two decimal digits, 0 to 9, from a bank of ten switches in which switch i stands for digit i. It turns the active switch into its binary value. A load-A strobe copies that value into operand register A, and a load-B strobe copies it into operand register B. Four operation-select inputs then start one of four unsigned operations on the stored operands.

Addition and subtraction finish in a single cycle. Subtraction returns the magnitude of the difference and a separate negative flag. Multiplication runs as a loop that adds A to an accumulator B times. Division runs as a loop that subtracts B from the remaining dividend and counts the subtractions, and only the quotient is returned. A divisor of zero ends at once with a quotient of zero and an error flag, so no loop can run without end.

The result, the negative flag and the error flag are registered together and stay put until the next operation completes. A busy output covers each loop, and a done output pulses for one cycle when a result becomes valid. Display formatting and switch debouncing belong to other blocks.

Top module: `digit_calc`

## Requirements
- R1: A synchronous active-low reset clears operand A, operand B, the result, the negative flag, the error flag, busy, done and the loop state. An addition started right after reset therefore yields 0.
- R2: With exactly one switch sw_i[i] high, a load-A or load-B pulse stores the value i in that operand. Each strobe writes only its own operand.
- R3: When no switch is high or more than one switch is high, the entry decodes to 0 and a load stores 0.
- R4: Addition sets result_o to A+B with neg_o and div_err_o at 0. done_o is high in the cycle after the start edge.
- R5: Subtraction sets result_o to |A−B|. neg_o is 1 exactly when B>A, and 0 when A≥B. done_o follows the start edge as in R4.
- R6: Multiplication sets result_o to A×B with neg_o at 0. done_o goes high after B+2 clock edges, counting the start edge. result_o never exceeds 81.
- R7: Division with B≠0 sets result_o to floor(A/B) with neg_o at 0. done_o goes high after floor(A/B)+2 edges, counting the start edge.
- R8: Division with B=0 sets result_o to 0 and div_err_o to 1, with done_o after the start edge. div_err_o holds until the next completion of any other kind, which clears it.
- R9: busy_o is high from the edge after a multiply or divide start until the finishing edge. busy_o and done_o are never high together. Operation selects that arrive while busy_o is high are ignored.
- R10: done_o is a one-cycle pulse per operation, and result_o changes only at an edge that raises done_o.
- R11: When several operation selects are high together, the winner is chosen in the order add, subtract, multiply, divide.
- R12: An operand load during a running loop does not change that loop's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_i | input | 10 | One-hot digit switches; bit i is digit i |
| load_a_i | input | 1 | Store the decoded entry into operand A |
| load_b_i | input | 1 | Store the decoded entry into operand B |
| op_add_i | input | 1 | Start an addition |
| op_sub_i | input | 1 | Start a subtraction |
| op_mul_i | input | 1 | Start a multiplication |
| op_div_i | input | 1 | Start a division |
| result_o | output | 8 | Unsigned result or magnitude |
| neg_o | output | 1 | Result is negative (subtraction only) |
| div_err_o | output | 1 | The last division had a zero divisor |
| busy_o | output | 1 | A multiply or divide loop is running |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
Each result is due a fixed number of edges after the edge that samples the select:
- Addition, subtraction and division by zero: one edge.
- Multiplication: B+2 edges.
- Division: quotient+2 edges.

The bench drives the select for exactly one cycle, counts edges while it watches done_o at each falling edge, and compares that count with the expected latency held in its vector table. It samples the result, the negative flag and the error flag in that same done cycle. It checks one cycle later that done_o has dropped again.

// File: rtl/calc_pkg.sv
// Package: types and sizes shared by the calculator datapath.
// Assumes decimal operands, so a ten-position entry bank by default.
package calc_pkg;
    localparam int unsigned DIGITS = 10;
    localparam int unsigned OPW    = $clog2(DIGITS);
    localparam int unsigned RESW   = 8;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2
    } state_e;
endpackage

// File: rtl/digit_decoder.sv
// Module: turns a one-hot switch bank into the binary digit it selects.
// Assumes nothing about the switch pattern: no switch high or several
// switches high both give zero.
module digit_decoder #(
    parameter int unsigned DIGITS = calc_pkg::DIGITS,
    parameter int unsigned OPW    = calc_pkg::OPW
) (
    input  logic [DIGITS-1:0] sw,
    output logic [OPW-1:0]    value
);
    localparam int unsigned CNTW = $clog2(DIGITS + 1);

    logic [CNTW-1:0] hits;
    logic [OPW-1:0]  idx;

    // Count the active switches and remember the position of one of them.
    always_comb begin
        hits = '0;
        idx  = '0;
        for (int i = 0; i < DIGITS; i++) begin
            if (sw[i]) begin
                hits = hits + CNTW'(1);
                idx  = OPW'(i);
            end
        end
        value = (hits == CNTW'(1)) ? idx : '0;
    end
endmodule

// File: rtl/op_select.sv
// Module: picks one operation from the four select inputs by fixed
// priority (add, sub, mul, div). Assumes the selects are already
// synchronous to clk.
module op_select (
    input  logic           sel_add,
    input  logic           sel_sub,
    input  logic           sel_mul,
    input  logic           sel_div,
    output logic           start,
    output calc_pkg::op_e  op
);
    import calc_pkg::*;

    // Priority encode the select lines.
    always_comb begin
        start = sel_add | sel_sub | sel_mul | sel_div;
        if (sel_add)      op = OP_ADD;
        else if (sel_sub) op = OP_SUB;
        else if (sel_mul) op = OP_MUL;
        else              op = OP_DIV;
    end
endmodule

// File: rtl/calc_engine.sv
// Module: runs one operation on two digit operands. Add and sub finish
// at the start edge. Mul loops by repeated addition and div by repeated
// subtraction, with the operands captured at start. Assumes start is
// only acted on while idle.
module calc_engine #(
    parameter int unsigned OPW  = calc_pkg::OPW,
    parameter int unsigned RESW = calc_pkg::RESW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  calc_pkg::op_e   op,
    input  logic [OPW-1:0]  opa,
    input  logic [OPW-1:0]  opb,
    output logic [RESW-1:0] result,
    output logic            neg,
    output logic            err,
    output logic            busy,
    output logic            done
);
    import calc_pkg::*;

    state_e          state;
    logic [RESW-1:0] mcand;
    logic [RESW-1:0] acc;
    logic [RESW-1:0] rem;
    logic [RESW-1:0] divisor;
    logic [OPW-1:0]  cnt;
    logic [RESW-1:0] ea;
    logic [RESW-1:0] eb;

    // Widen the operands to result width.
    always_comb begin
        ea = RESW'(opa);
        eb = RESW'(opb);
    end

    // Busy covers the loop states.
    always_comb busy = (state != ST_IDLE);

    // Sequencer: start, iterate, finish, with one done pulse per finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mcand   <= '0;
            acc     <= '0;
            rem     <= '0;
            divisor <= '0;
            cnt     <= '0;
            result  <= '0;
            neg     <= 1'b0;
            err     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        unique case (op)
                            OP_ADD: begin
                                result <= ea + eb;
                                neg    <= 1'b0;
                                err    <= 1'b0;
                                done   <= 1'b1;
                            end
                            OP_SUB: begin
                                if (eb > ea) begin
                                    result <= eb - ea;
                                    neg    <= 1'b1;
                                end else begin
                                    result <= ea - eb;
                                    neg    <= 1'b0;
                                end
                                err  <= 1'b0;
                                done <= 1'b1;
                            end
                            OP_MUL: begin
                                mcand <= ea;
                                cnt   <= opb;
                                acc   <= '0;
                                state <= ST_MUL;
                            end
                            OP_DIV: begin
                                if (opb == '0) begin
                                    result <= '0;
                                    neg    <= 1'b0;
                                    err    <= 1'b1;
                                    done   <= 1'b1;
                                end else begin
                                    divisor <= eb;
                                    rem     <= ea;
                                    acc     <= '0;
                                    state   <= ST_DIV;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_MUL: begin
                    if (cnt == '0) begin
                        result <= acc;
                        neg    <= 1'b0;
                        err    <= 1'b0;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        acc <= acc + mcand;
                        cnt <= cnt - OPW'(1);
                    end
                end
                ST_DIV: begin
                    if (rem >= divisor) begin
                        rem <= rem - divisor;
                        acc <= acc + RESW'(1);
                    end else begin
                        result <= acc;
                        neg    <= 1'b0;
                        err    <= 1'b0;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/digit_calc.sv
// Module: top of the digit calculator. Decodes the switch bank, holds
// operands A and B, and hands the selected operation to the engine.
// Assumes all inputs are synchronous and debounced.
module digit_calc #(
    parameter int unsigned DIGITS = calc_pkg::DIGITS,
    parameter int unsigned RESW   = calc_pkg::RESW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIGITS-1:0] sw_i,
    input  logic              load_a_i,
    input  logic              load_b_i,
    input  logic              op_add_i,
    input  logic              op_sub_i,
    input  logic              op_mul_i,
    input  logic              op_div_i,
    output logic [RESW-1:0]   result_o,
    output logic              neg_o,
    output logic              div_err_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int unsigned OPW = $clog2(DIGITS);

    logic [OPW-1:0] entry;
    logic [OPW-1:0] opa_q;
    logic [OPW-1:0] opb_q;
    logic           start;
    logic           go;
    calc_pkg::op_e  op;

    digit_decoder #(.DIGITS(DIGITS), .OPW(OPW)) u_dec (
        .sw    (sw_i),
        .value (entry)
    );

    // Operand registers, each written only by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            if (load_a_i) opa_q <= entry;
            if (load_b_i) opb_q <= entry;
        end
    end

    op_select u_sel (
        .sel_add (op_add_i),
        .sel_sub (op_sub_i),
        .sel_mul (op_mul_i),
        .sel_div (op_div_i),
        .start   (start),
        .op      (op)
    );

    // Selects are ignored while a loop runs.
    always_comb go = start & ~busy_o;

    calc_engine #(.OPW(OPW), .RESW(RESW)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (go),
        .op     (op),
        .opa    (opa_q),
        .opb    (opb_q),
        .result (result_o),
        .neg    (neg_o),
        .err    (div_err_o),
        .busy   (busy_o),
        .done   (done_o)
    );
endmodule

// File: rtl/digit_calc_checks.sv
// Module: checker bound to digit_calc; relates its outputs over time.
module digit_calc_checks #(
    parameter int unsigned RESW = calc_pkg::RESW
) (
    input logic            clk,
    input logic            rst_n,
    input logic [RESW-1:0] result_o,
    input logic            neg_o,
    input logic            div_err_o,
    input logic            busy_o,
    input logic            done_o
);
    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    // R9
    busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R8
    div_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_err_o |-> (result_o == '0 && !neg_o));

    // R6
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_o <= RESW'(81));

    // R5
    neg_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        neg_o |-> (result_o <= RESW'(9) && result_o != '0));
endmodule

bind digit_calc digit_calc_checks #(.RESW(RESW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .result_o  (result_o),
    .neg_o     (neg_o),
    .div_err_o (div_err_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/digit_calc_bench.sv
`timescale 1ns/1ps
module digit_calc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] sw = '0;
    logic       load_a = 0, load_b = 0;
    logic       op_add = 0, op_sub = 0, op_mul = 0, op_div = 0;
    logic [7:0] result;
    logic       neg, err, busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    digit_calc u_digit_calc (
        .clk(clk), .rst_n(rst_n), .sw_i(sw),
        .load_a_i(load_a), .load_b_i(load_b),
        .op_add_i(op_add), .op_sub_i(op_sub), .op_mul_i(op_mul), .op_div_i(op_div),
        .result_o(result), .neg_o(neg), .div_err_o(err),
        .busy_o(busy), .done_o(done)
    );

    // Fields: a[25:22] b[21:18] op[17:16] res[15:8] neg[7] err[6] lat[5:0]
    // op: 0 add, 1 sub, 2 mul, 3 div
    localparam int NV = 14;
    localparam logic [25:0] VEC [NV] = '{
        {4'd3, 4'd4, 2'd0, 8'd7,  1'b0, 1'b0, 6'd1},   // R4
        {4'd9, 4'd9, 2'd0, 8'd18, 1'b0, 1'b0, 6'd1},   // R4
        {4'd7, 4'd2, 2'd1, 8'd5,  1'b0, 1'b0, 6'd1},   // R5
        {4'd2, 4'd7, 2'd1, 8'd5,  1'b1, 1'b0, 6'd1},   // R5
        {4'd4, 4'd4, 2'd1, 8'd0,  1'b0, 1'b0, 6'd1},   // R5
        {4'd9, 4'd9, 2'd2, 8'd81, 1'b0, 1'b0, 6'd11},  // R6
        {4'd0, 4'd5, 2'd2, 8'd0,  1'b0, 1'b0, 6'd7},   // R6
        {4'd6, 4'd0, 2'd2, 8'd0,  1'b0, 1'b0, 6'd2},   // R6
        {4'd3, 4'd7, 2'd2, 8'd21, 1'b0, 1'b0, 6'd9},   // R6
        {4'd9, 4'd2, 2'd3, 8'd4,  1'b0, 1'b0, 6'd6},   // R7
        {4'd2, 4'd9, 2'd3, 8'd0,  1'b0, 1'b0, 6'd2},   // R7
        {4'd8, 4'd8, 2'd3, 8'd1,  1'b0, 1'b0, 6'd3},   // R7
        {4'd5, 4'd0, 2'd3, 8'd0,  1'b0, 1'b1, 6'd1},   // R8
        {4'd1, 4'd1, 2'd0, 8'd2,  1'b0, 1'b0, 6'd1}    // R8 error cleared
    };

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [9:0] pat, input bit to_b);
        @(negedge clk);
        sw = pat;
        load_a = !to_b;
        load_b = to_b;
        @(negedge clk);
        load_a = 0;
        load_b = 0;
    endtask

    // Pulse the selects for one cycle, return edges until done.
    task automatic start_op(input logic [3:0] sel, output int lat);
        @(negedge clk);
        {op_div, op_mul, op_sub, op_add} = sel;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        {op_div, op_mul, op_sub, op_add} = '0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_vec(input logic [25:0] v, input string req);
        int lat;
        load(10'(1) << v[25:22], 1'b0);
        load(10'(1) << v[21:18], 1'b1);
        start_op(4'(1) << v[17:16], lat);
        check(req, lat, int'(v[5:0]), "latency");
        check(req, int'(result), int'(v[15:8]), "result");
        check(req, int'(neg), int'(v[7]), "neg");
        check(req, int'(err), int'(v[6]), "err");
        @(negedge clk);
        check("R10", int'(done), 0, "done pulse width");
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", int'(result), 0, "result after reset");
        check("R1", int'(busy) + int'(done) + int'(neg) + int'(err), 0, "flags after reset");
        rst_n = 1;
        start_op(4'b0001, lat);
        check("R1", int'(result), 0, "cleared operands sum");

        for (int i = 0; i < NV; i++) run_vec(VEC[i], "table");

        // R2 every digit through both operands
        for (int d = 0; d < 10; d++) begin
            load(10'(1) << d, 1'b0);
            load(10'(0), 1'b1);
            start_op(4'b0001, lat);
            check("R2", int'(result), d, "digit on A");
        end
        load(10'(1) << 6, 1'b1);
        start_op(4'b0001, lat);
        check("R2", int'(result), 15, "B load keeps A");

        // R3 no switch / several switches
        load(10'b0, 1'b0);
        load(10'(1) << 5, 1'b1);
        start_op(4'b0001, lat);
        check("R3", int'(result), 5, "no switch decodes zero");
        load(10'b0000100100, 1'b0);
        start_op(4'b0001, lat);
        check("R3", int'(result), 5, "two switches decode zero");

        // R11 priority
        load(10'(1) << 8, 1'b0);
        load(10'(1) << 3, 1'b1);
        start_op(4'b1100, lat);
        check("R11", int'(result), 24, "mul over div");
        check("R11", lat, 5, "mul over div latency");
        start_op(4'b1111, lat);
        check("R11", int'(result), 11, "add wins");
        start_op(4'b1010, lat);
        check("R11", int'(neg) * 100 + int'(result), 5, "sub over div");

        // R9 / R12 selects and loads ignored while busy
        load(10'(1) << 9, 1'b0);
        load(10'(1) << 9, 1'b1);
        @(negedge clk);
        op_mul = 1;
        @(negedge clk);
        op_mul = 0;
        check("R9", int'(busy), 1, "busy during mul");
        op_add = 1;
        sw = 10'(1) << 1;
        load_a = 1;
        @(negedge clk);
        op_add = 0;
        load_a = 0;
        check("R9", int'(done), 0, "add ignored while busy");
        lat = 2;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R12", int'(result), 81, "load during loop");
        check("R9", lat, 11, "loop length unchanged");
        check("R9", int'(busy), 0, "busy low at done");
        start_op(4'b0001, lat);
        check("R12", int'(result), 10, "new A used after loop");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule